// File: doc/BRIEF.md
# Serially Programmed Pulse-Width Modulator

This block turns its system clock into a pulse train. Software-side logic, or another block, sends a 24-bit frame over a three-wire shift interface made of an active-low select, a serial clock and serial data. The frame carries three bytes: a high-time count, a period count and a control byte. Two down counters then produce an output whose period is the period count and whose high time is the high-time count. Both are measured in prescaled clock cycles.

The control byte either lets the counters run on every clock, or halves their rate, or stops them in a low-power state. A digital over-limit flag from outside forces the output low for as long as it is raised. The select, serial clock and serial data inputs are synchronised into the clock domain. The serial clock must therefore be several times slower than the system clock.

Top module: `serial_pwm_gen`

## Requirements
- R1: A synchronous active-high reset clears the bit counter, all three registers and the output. The output is low while reset is held. After reset, with no frame sent, it stays low, because the high time is zero and the period count is zero.
- R2: A frame is 24 bits, sampled on rising serial-clock edges while select is low, MSB first. The order is: high-time byte, then period byte, then control byte. After the 24th bit the three registers load together.
- R3: If select rises before the 24th bit, the partial frame is discarded and the bit counter restarts. The registers and the output pattern stay as they were, and the next complete frame loads correctly.
- R4: The output period equals the period byte in prescaled cycles, with a period byte of 0 meaning 256.
- R5: The high time equals the high-time byte in prescaled cycles. A high-time byte of 0 gives a constantly low output. A high-time byte greater than or equal to the period gives a constantly high output.
- R6: Control bits [1:0] = 01 make the counters advance every second clock, so both the high time and the low time double in clock cycles. Control bits = 00 advance them every clock.
- R7: Control bit 1 = 1 selects low power. The counters stop and the output goes low one clock after the control byte loads. Loading 00 again resumes the pattern.
- R8: New high-time and period values take effect only at the start of the next output period. The period in progress when a frame loads completes with the old values.
- R9: While the over-limit input is high, the output is low from the following clock. When it is released, the counter pattern reappears on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counters and output are registered on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select for the serial interface |
| sck | input | 1 | Serial clock; data sampled on its rising edge |
| sdi | input | 1 | Serial data, MSB first |
| over_limit | input | 1 | High when the monitored level exceeds its limit; forces output low |
| pwm_out | output | 1 | Registered pulse-width modulated output |

## Verification
A miscounted bit counter or a misaligned shift register shows up as wrong pulse lengths in the first full period after the frame loads. A period-counter fault changes the spacing between rising edges within one period. A fault in the high-time counter shows within the same period as a wrong high-run length, or as an output stuck high or low. Reloading at the wrong moment splits the period that straddles a load, and this is visible as one odd pulse right after the update. Prescale, sleep and override faults change the output level or run lengths within one to two clocks of the event.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_HALF  = 2'b01,
    MODE_SLEEP = 2'b10
  } rate_mode_e;

  function automatic rate_mode_e decode_mode(input logic [1:0] ctl);
    if (ctl[1])      return MODE_SLEEP;
    else if (ctl[0]) return MODE_HALF;
    else             return MODE_RUN;
  endfunction

endpackage

// File: rtl/spwm_sync.sv
module spwm_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spwm_loader.sv
module spwm_loader #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_n,
  input  logic               sck,
  input  logic               sdi,
  output logic               load_stb,
  output logic [FRAME_W-1:0] word
);
  localparam int CW = $clog2(FRAME_W);
  localparam logic [CW-1:0] LAST = CW'(FRAME_W - 1);

  logic               sck_d;
  logic [CW-1:0]      bit_cnt;
  logic [FRAME_W-2:0] shreg;
  logic               sck_rise;

  assign sck_rise = sck & ~sck_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      bit_cnt  <= '0;
      shreg    <= '0;
      load_stb <= 1'b0;
      word     <= '0;
    end else begin
      sck_d    <= sck;
      load_stb <= 1'b0;
      if (sel_n) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        if (bit_cnt == LAST) begin
          word     <= {shreg, sdi};
          load_stb <= 1'b1;
          bit_cnt  <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= {shreg[FRAME_W-3:0], sdi};
        end
      end
    end
  end
endmodule

// File: rtl/spwm_prescale.sv
module spwm_prescale
  import spwm_pkg::*;
#(
  parameter int DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  rate_mode_e mode,
  output logic       tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst)                    phase <= '0;
    else if (mode != MODE_HALF) phase <= '0;
    else if (phase == TOP)      phase <= '0;
    else                        phase <= phase + 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_RUN:  tick = 1'b1;
      MODE_HALF: tick = (phase == TOP);
      default:   tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/spwm_core.sv
module spwm_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [DW-1:0] hi_next,
  input  logic [DW-1:0] per_next,
  output logic          level
);
  localparam int CNT_W = DW + 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << DW;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] per_cnt;
  logic [DW-1:0]    hi_cnt;
  logic [CNT_W-1:0] per_eff;
  logic             at_end;

  always_comb begin
    if (per_next == '0) per_eff = FULL;
    else                per_eff = {1'b0, per_next};
  end

  assign at_end = (per_cnt <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      per_cnt <= '0;
      hi_cnt  <= '0;
    end else if (tick) begin
      if (at_end) begin
        per_cnt <= per_eff;
        hi_cnt  <= hi_next;
      end else begin
        per_cnt <= per_cnt - 1'b1;
        if (hi_cnt != '0) hi_cnt <= hi_cnt - 1'b1;
      end
    end
  end

  assign level = (hi_cnt != '0);
endmodule

// File: rtl/serial_pwm_gen.sv
module serial_pwm_gen
  import spwm_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_DIV    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  input  logic sck,
  input  logic sdi,
  input  logic over_limit,
  output logic pwm_out
);
  localparam int NREG    = 3;
  localparam int FRAME_W = DW * NREG;

  logic [2:0]         sync_q;
  logic               sel_s;
  logic               sck_s;
  logic               sdi_s;
  logic               load_stb;
  logic [FRAME_W-1:0] word;
  logic [DW-1:0]      hi_sh;
  logic [DW-1:0]      per_sh;
  logic [1:0]         ctl_sh;
  logic               ctl_unused;
  rate_mode_e         mode;
  logic               sleep;
  logic               tick;
  logic               level;

  spwm_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sel_n, sck, sdi}),
    .q   (sync_q)
  );

  assign sel_s = sync_q[2];
  assign sck_s = sync_q[1];
  assign sdi_s = sync_q[0];

  spwm_loader #(.FRAME_W(FRAME_W)) u_load (
    .clk      (clk),
    .rst      (rst),
    .sel_n    (sel_s),
    .sck      (sck_s),
    .sdi      (sdi_s),
    .load_stb (load_stb),
    .word     (word)
  );

  assign ctl_unused = ^word[DW-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_sh  <= '0;
      per_sh <= '0;
      ctl_sh <= '0;
    end else if (load_stb) begin
      hi_sh  <= word[FRAME_W-1 -: DW];
      per_sh <= word[FRAME_W-DW-1 -: DW];
      ctl_sh <= word[1:0];
    end
  end

  assign mode  = decode_mode(ctl_sh);
  assign sleep = (mode == MODE_SLEEP);

  spwm_prescale #(.DIV(HALF_DIV)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .mode (mode),
    .tick (tick)
  );

  spwm_core #(.DW(DW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .hi_next  (hi_sh),
    .per_next (per_sh),
    .level    (level)
  );

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= level & ~over_limit & ~sleep;
  end
endmodule

// File: rtl/spwm_checker.sv
module spwm_checker (
  input logic clk,
  input logic rst,
  input logic over_limit,
  input logic pwm_out,
  input logic sleep,
  input logic tick,
  input logic level,
  input logic load_stb,
  input logic sel_s
);
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pwm_out);

  a_r9_override_low: assert property (@(posedge clk) disable iff (rst)
    over_limit |=> !pwm_out);

  a_r7_sleep_low: assert property (@(posedge clk) disable iff (rst)
    sleep |=> !pwm_out);

  a_r7_sleep_no_tick: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !tick);

  a_r8_level_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(level));

  a_r3_load_needs_select: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> $past(!sel_s));

  a_r2_mode_changes_on_load: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> $stable(sleep));
endmodule

bind serial_pwm_gen spwm_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .over_limit (over_limit),
  .pwm_out    (pwm_out),
  .sleep      (sleep),
  .tick       (tick),
  .level      (level),
  .load_stb   (load_stb),
  .sel_s      (sel_s)
);

// File: tb/sim_serial_pwm_gen.sv
`timescale 1ns/1ps
module sim_serial_pwm_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic over_limit = 1'b0;
  logic pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit mon_en = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  serial_pwm_gen u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .over_limit(over_limit), .pwm_out(pwm_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bits(input logic [23:0] w, input int nbits);
    @(negedge clk);
    sel_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[23 - i];
      sck = 1'b0;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
    end
    sck = 1'b0;
    repeat (4) @(negedge clk);
    sel_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] hi, input logic [7:0] per, input logic [7:0] ctl);
    send_bits({hi, per, ctl}, 24);
  endtask

  task automatic settle();
    repeat (1100) @(posedge clk);
  endtask

  task automatic arm();
    @(posedge pwm_out);
    @(negedge clk);
    @(posedge clk);
  endtask

  task automatic push(input int hi, input int lo, input string tag);
    exp_q.push_back({hi[15:0], lo[15:0]});
    tag_q.push_back(tag);
  endtask

  task automatic expect_pulses(input int hi, input int lo, input int n, input string tag);
    arm();
    for (int i = 0; i < n; i++) push(hi, lo, tag);
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    mon_en = 1'b0;
  endtask

  task automatic check_level(input logic val, input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out !== val) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  // monitor: measures each high run and following low run between rising edges
  initial begin
    int hi = 0;
    int lo = 0;
    bit started = 0;
    logic prev = 1'b0;
    logic [31:0] item;
    string t;
    forever begin
      @(negedge clk);
      if (rst) begin
        started = 0;
        prev = 1'b0;
      end else begin
        if (pwm_out && !prev) begin
          if (started && mon_en && exp_q.size() > 0) begin
            item = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(hi == int'(item[31:16]) && lo == int'(item[15:0]), t,
                hi * 1000 + lo, int'(item[31:16]) * 1000 + int'(item[15:0]));
          end
          started = 1;
          hi = 1;
          lo = 0;
        end else if (pwm_out) hi++;
        else lo++;
        prev = pwm_out;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0, "R1 low during reset", pwm_out, 0);
    rst = 1'b0;
    check_level(1'b0, 600, "R1 low after reset with no frame");

    // R2 frame order, R4 period, R5 high time
    send_frame(8'd3, 8'd10, 8'd0);
    settle();
    expect_pulses(3, 7, 3, "R2 R4 R5 pulse 3 of 10");

    // R3 aborted frame ignored, next full frame fine
    send_bits({8'd50, 8'd60, 8'd0}, 12);
    settle();
    expect_pulses(3, 7, 2, "R3 partial frame discarded");
    send_frame(8'd4, 8'd8, 8'd0);
    settle();
    expect_pulses(4, 4, 2, "R3 full frame after abort");

    // R4 period byte 0 means 256, period 255
    send_frame(8'd128, 8'd0, 8'd0);
    settle();
    expect_pulses(128, 128, 2, "R4 period zero is 256");
    send_frame(8'd1, 8'd255, 8'd0);
    settle();
    expect_pulses(1, 254, 2, "R4 period 255");

    // R5 high time zero
    send_frame(8'd0, 8'd20, 8'd0);
    settle();
    check_level(1'b0, 600, "R5 high time zero always low");

    // R6 divide by two
    send_frame(8'd2, 8'd5, 8'd1);
    settle();
    expect_pulses(4, 6, 3, "R6 half rate doubles runs");

    // R8 update takes effect at next period
    send_frame(8'd100, 8'd250, 8'd0);
    settle();
    arm();
    push(100, 150, "R8 straddling period keeps old values");
    push(10, 30, "R8 new values next period");
    push(10, 30, "R8 new values steady");
    mon_en = 1'b1;
    repeat (20) @(posedge clk);
    send_frame(8'd10, 8'd40, 8'd0);
    wait (exp_q.size() == 0);
    mon_en = 1'b0;

    // R5 high time >= period
    send_frame(8'd9, 8'd9, 8'd0);
    settle();
    check_level(1'b1, 300, "R5 high equal period always high");
    send_frame(8'd200, 8'd50, 8'd0);
    settle();
    check_level(1'b1, 300, "R5 high above period always high");

    // R9 over-limit override
    @(negedge clk);
    over_limit = 1'b1;
    @(negedge clk);
    chk(pwm_out == 1'b0, "R9 low one clock after over_limit", pwm_out, 0);
    check_level(1'b0, 50, "R9 held low while over_limit");
    over_limit = 1'b0;
    @(negedge clk);
    chk(pwm_out == 1'b1, "R9 restored one clock after release", pwm_out, 1);

    // R7 low power
    send_frame(8'd200, 8'd50, 8'd2);
    check_level(1'b0, 300, "R7 low power holds output low");
    send_frame(8'd200, 8'd50, 8'd0);
    repeat (10) @(negedge clk);
    check_level(1'b1, 200, "R7 pattern resumes after wake");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule